// File: doc/BRIEF.md
# UART Query-Response Sequencer

This block is a small control sequencer placed between a byte-wide UART and user logic. It waits for the UART to report a received byte and reads that byte with a one-cycle strobe. If the byte is the trigger character, the block answers with two bytes. These come from user logic and are called X and Y. The block sends X first and Y second through the UART transmitter.

The sequencer runs on a fast system clock, while the UART shifts bits at a slow baud rate. Because of this, the UART's transmit-empty flag lags well behind each write. After every write the sequencer waits for that flag to drop before it waits for the flag to rise again. This stops the second byte from overwriting the first. X and Y are latched when the trigger byte is recognised, so a response that is already under way is not affected by later changes to those inputs. Reception and transmission use separate lines, so a byte that arrives during a response stays unread until the response is finished.

Top module: `uart_query_seq`

## Requirements
- R1: While `rx_ready` is 0 and no response is in progress, `rd_pulse` and `wr_pulse` stay 0.
- R2: When `rx_ready` is 1 in the idle state, `rd_pulse` goes high for exactly one cycle, starting on the next clock edge. The received byte is evaluated in that cycle.
- R3: A received byte equal to 8'h31 (ASCII '1', all 8 bits compared) starts a response. Any other value returns the block to idle without a write.
- R4: A write is issued only after `tx_idle` has been sampled as 1. While `tx_idle` is 0, the write is held off.
- R5: The first write carries X and the second carries Y. Each `wr_pulse` lasts exactly one cycle, and `tx_byte` holds the byte being written during that cycle.
- R6: After each write, no further write is issued until `tx_idle` has gone to 0 and then returned to 1, however long `tx_idle` stays 1 after the write.
- R7: When `tx_idle` falls after the second write, the block returns to idle. A byte that arrived during the response is read only then, and it is answered normally.
- R8: `x_in` and `y_in` are captured when the trigger byte is matched. Changes to them afterwards do not alter the bytes sent in that response.
- R9: A synchronous active-high `rst` returns the block to idle with both strobes at 0, even in the middle of a response.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_ready | input | 1 | UART has a received byte waiting |
| rx_byte | input | DW | Received byte from UART |
| rd_pulse | output | 1 | One-cycle read strobe to UART |
| tx_idle | input | 1 | UART transmit buffer empty |
| wr_pulse | output | 1 | One-cycle write strobe to UART |
| tx_byte | output | DW | Byte presented to UART transmitter |
| x_in | input | DW | First response byte from user logic |
| y_in | input | DW | Second response byte from user logic |

## Verification
The hardest case to reach from the ports is the stale empty flag. After a write, `tx_idle` must stay 1 for many cycles before it falls, and a naive sequencer would then issue Y on top of X. The bench's behavioural UART model has a programmable delay between accepting a write and dropping the flag. A long-delay run counts every write that arrives while the model is still busy. Further directed runs hold `tx_idle` low before the first write, change X and Y in the middle of a response, and present a second trigger while a response is being sent.

// File: rtl/qseq_pkg.sv
package qseq_pkg;

  typedef enum logic [2:0] {
    S_IDLE  = 3'd0,
    S_READ  = 3'd1,
    S_WAIT1 = 3'd2,
    S_WR1   = 3'd3,
    S_SENT1 = 3'd4,
    S_WAIT2 = 3'd5,
    S_WR2   = 3'd6,
    S_SENT2 = 3'd7
  } qs_state_t;

  localparam int QS_MAXW = 32;

  // Trigger comparison over the low w bits.
  function automatic logic qs_is_trigger(input logic [QS_MAXW-1:0] b,
                                         input logic [QS_MAXW-1:0] t,
                                         input int w);
    logic [QS_MAXW-1:0] m;
    m = (w >= QS_MAXW) ? '1 : ((QS_MAXW'(1) << w) - QS_MAXW'(1));
    return ((b ^ t) & m) == '0;
  endfunction

  // Second-byte phase select.
  function automatic logic qs_second_phase(input qs_state_t s);
    return (s == S_WAIT2) || (s == S_WR2) || (s == S_SENT2);
  endfunction

endpackage

// File: rtl/qseq_hold.sv
module qseq_hold #(
  parameter int DW = 8,
  parameter int NB = 2
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  load,
  input  logic [NB-1:0][DW-1:0] din,
  input  logic [$clog2(NB)-1:0] sel,
  output logic [DW-1:0]         dout
);
  logic [NB-1:0][DW-1:0] hold_q;

  for (genvar i = 0; i < NB; i++) begin : g_slot
    always_ff @(posedge clk) begin
      if (rst)       hold_q[i] <= '0;
      else if (load) hold_q[i] <= din[i];
    end
  end

  assign dout = hold_q[sel];
endmodule

// File: rtl/qseq_fsm.sv
module qseq_fsm
  import qseq_pkg::*;
#(
  parameter int DW = 8,
  parameter logic [DW-1:0] TRIG = 8'h31
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          rx_ready,
  input  logic [DW-1:0] rx_byte,
  input  logic          tx_idle,
  output logic          rd_pulse,
  output logic          wr_pulse,
  output logic          hit,
  output logic          capture,
  output logic          sel_y,
  output qs_state_t     state
);
  qs_state_t state_q, state_d;

  assign hit = qs_is_trigger(QS_MAXW'(rx_byte), QS_MAXW'(TRIG), DW);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      S_IDLE:  if (rx_ready) state_d = S_READ;
      S_READ:  state_d = hit ? S_WAIT1 : S_IDLE;
      S_WAIT1: if (tx_idle)  state_d = S_WR1;
      S_WR1:   state_d = S_SENT1;
      S_SENT1: if (!tx_idle) state_d = S_WAIT2;
      S_WAIT2: if (tx_idle)  state_d = S_WR2;
      S_WR2:   state_d = S_SENT2;
      S_SENT2: if (!tx_idle) state_d = S_IDLE;
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state_q <= S_IDLE;
    else     state_q <= state_d;
  end

  assign rd_pulse = (state_q == S_READ);
  assign wr_pulse = (state_q == S_WR1) || (state_q == S_WR2);
  assign capture  = rd_pulse && hit;
  assign sel_y    = qs_second_phase(state_q);
  assign state    = state_q;
endmodule

// File: rtl/uart_query_seq.sv
module uart_query_seq
  import qseq_pkg::*;
#(
  parameter int DW = 8,
  parameter logic [DW-1:0] TRIG = 8'h31
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          rx_ready,
  input  logic [DW-1:0] rx_byte,
  output logic          rd_pulse,
  input  logic          tx_idle,
  output logic          wr_pulse,
  output logic [DW-1:0] tx_byte,
  input  logic [DW-1:0] x_in,
  input  logic [DW-1:0] y_in
);
  localparam int NB = 2;

  // Internal events for the checker.
  logic      ev_hit;
  logic      ev_capture;
  logic      ev_sel_y;
  qs_state_t ev_state;

  qseq_fsm #(.DW(DW), .TRIG(TRIG)) u_fsm (
    .clk      (clk),
    .rst      (rst),
    .rx_ready (rx_ready),
    .rx_byte  (rx_byte),
    .tx_idle  (tx_idle),
    .rd_pulse (rd_pulse),
    .wr_pulse (wr_pulse),
    .hit      (ev_hit),
    .capture  (ev_capture),
    .sel_y    (ev_sel_y),
    .state    (ev_state)
  );

  qseq_hold #(.DW(DW), .NB(NB)) u_hold (
    .clk  (clk),
    .rst  (rst),
    .load (ev_capture),
    .din  ({y_in, x_in}),
    .sel  (ev_sel_y),
    .dout (tx_byte)
  );
endmodule

// File: rtl/uart_query_seq_chk.sv
module uart_query_seq_chk #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst,
  input logic          rx_ready,
  input logic          rd_pulse,
  input logic          tx_idle,
  input logic          wr_pulse,
  input logic [DW-1:0] tx_byte,
  input logic          ev_hit
);
  // Armed from a write until the empty flag has been seen low.
  logic armed_q;
  always_ff @(posedge clk) begin
    if (rst)           armed_q <= 1'b0;
    else if (wr_pulse) armed_q <= 1'b1;
    else if (!tx_idle) armed_q <= 1'b0;
  end

  assert_rd_single_R2: assert property (@(posedge clk) disable iff (rst)
    rd_pulse |=> !rd_pulse);

  assert_nomatch_idle_R3: assert property (@(posedge clk) disable iff (rst)
    (rd_pulse && !ev_hit) |=> (!wr_pulse && !rd_pulse));

  assert_wr_after_empty_R4: assert property (@(posedge clk) disable iff (rst)
    $rose(wr_pulse) |-> $past(tx_idle));

  assert_wr_single_R5: assert property (@(posedge clk) disable iff (rst)
    wr_pulse |=> !wr_pulse);

  assert_no_overwrite_R6: assert property (@(posedge clk) disable iff (rst)
    armed_q |-> !wr_pulse);

  assert_no_read_in_write_R7: assert property (@(posedge clk) disable iff (rst)
    wr_pulse |-> !rd_pulse);

  assert_reset_quiet_R9: assert property (@(posedge clk)
    $past(rst) |-> (!rd_pulse && !wr_pulse));
endmodule

bind uart_query_seq uart_query_seq_chk #(.DW(DW)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .rx_ready (rx_ready),
  .rd_pulse (rd_pulse),
  .tx_idle  (tx_idle),
  .wr_pulse (wr_pulse),
  .tx_byte  (tx_byte),
  .ev_hit   (ev_hit)
);

// File: tb/sim_uart_query_seq.sv
`timescale 1ns/1ps
module sim_uart_query_seq;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       rx_ready = 1'b0;
  logic [7:0] rx_byte = 8'h00;
  logic       rd_pulse, wr_pulse, tx_idle;
  logic [7:0] tx_byte;
  logic [7:0] x_in = 8'h00, y_in = 8'h00;

  always #5 clk = ~clk;

  uart_query_seq u0 (
    .clk(clk), .rst(rst), .rx_ready(rx_ready), .rx_byte(rx_byte),
    .rd_pulse(rd_pulse), .tx_idle(tx_idle), .wr_pulse(wr_pulse),
    .tx_byte(tx_byte), .x_in(x_in), .y_in(y_in)
  );

  // Behavioural UART model
  int         lat = 6, busy = 10;
  logic       block = 1'b0;
  logic       empty_m = 1'b1;
  logic       pend = 1'b0;
  int         lat_cnt = 0, busy_cnt = 0;
  logic [7:0] txlog [0:15];
  int         nlog = 0, nrd = 0, overrun = 0, wide = 0;
  logic       wr_prev = 1'b0, rd_prev = 1'b0;

  assign tx_idle = empty_m & ~block;

  always @(negedge clk) begin
    if (rd_pulse) begin
      rx_ready = 1'b0;
      if (!rd_prev) nrd++;
    end
    if (rd_pulse && rd_prev) wide++;
    rd_prev = rd_pulse;
    if (wr_pulse && wr_prev) wide++;
    if (wr_pulse && !wr_prev) begin
      if (nlog < 16) txlog[nlog] = tx_byte;
      nlog++;
      if (pend || !empty_m) overrun++;
      pend = 1'b1;
      lat_cnt = lat;
    end else if (pend) begin
      if (lat_cnt > 0) lat_cnt--;
      else begin empty_m = 1'b0; pend = 1'b0; busy_cnt = busy; end
    end else if (!empty_m) begin
      if (busy_cnt > 0) busy_cnt--;
      else empty_m = 1'b1;
    end
    wr_prev = wr_pulse;
  end

  int nchk = 0, nerr = 0;
  logic done = 1'b0;

  task automatic check(input logic ok, input string tag, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic clear_model();
    nlog = 0; nrd = 0; overrun = 0; wide = 0;
    pend = 1'b0; empty_m = 1'b1;
  endtask

  task automatic send_rx(input logic [7:0] b);
    @(negedge clk);
    rx_byte = b;
    rx_ready = 1'b1;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // {rx byte, X, Y, expect response}
  localparam logic [24:0] VEC [7] = '{
    {8'h31, 8'hA5, 8'h5A, 1'b1},
    {8'h30, 8'h11, 8'h22, 1'b0},
    {8'h32, 8'h33, 8'h44, 1'b0},
    {8'h31, 8'h00, 8'hFF, 1'b1},
    {8'hB1, 8'h12, 8'h34, 1'b0},
    {8'h00, 8'h56, 8'h78, 1'b0},
    {8'h31, 8'h31, 8'h31, 1'b1}
  };

  initial begin
    idle(3);
    check(!rd_pulse && !wr_pulse, "R9 reset strobes", {rd_pulse, wr_pulse}, 0);
    rst = 1'b0;
    idle(20);
    check(nrd == 0 && nlog == 0, "R1 idle quiet", nrd + nlog, 0);

    // Vector table
    for (int i = 0; i < 7; i++) begin
      clear_model();
      x_in = VEC[i][16:9];
      y_in = VEC[i][8:1];
      send_rx(VEC[i][24:17]);
      idle(100);
      check(nrd == 1, "R2 one read", nrd, 1);
      if (VEC[i][0]) begin
        check(nlog == 2, "R3 response count", nlog, 2);
        check(txlog[0] == VEC[i][16:9], "R5 first byte X", txlog[0], VEC[i][16:9]);
        check(txlog[1] == VEC[i][8:1], "R5 second byte Y", txlog[1], VEC[i][8:1]);
      end else begin
        check(nlog == 0, "R3 no response", nlog, 0);
      end
      check(wide == 0, "R5 single cycle strobes", wide, 0);
      check(overrun == 0, "R6 no overwrite", overrun, 0);
    end

    // R4: empty flag held low before first write
    clear_model();
    x_in = 8'h61; y_in = 8'h62;
    block = 1'b1;
    send_rx(8'h31);
    idle(40);
    check(nlog == 0, "R4 write held while not empty", nlog, 0);
    block = 1'b0;
    idle(100);
    check(nlog == 2 && txlog[0] == 8'h61, "R4 write after empty", nlog, 2);

    // R6: long lag between write and flag fall
    clear_model();
    lat = 60; busy = 15;
    x_in = 8'hC3; y_in = 8'h3C;
    send_rx(8'h31);
    idle(400);
    check(overrun == 0, "R6 long lag no overwrite", overrun, 0);
    check(nlog == 2 && txlog[0] == 8'hC3 && txlog[1] == 8'h3C,
          "R6 long lag bytes", {txlog[0], txlog[1]}, 16'hC33C);
    lat = 6; busy = 10;

    // R8: inputs change mid-response
    clear_model();
    x_in = 8'h11; y_in = 8'h22;
    send_rx(8'h31);
    idle(4);
    x_in = 8'hAA; y_in = 8'hBB;
    idle(100);
    check(nlog == 2 && txlog[0] == 8'h11, "R8 X captured", txlog[0], 8'h11);
    check(txlog[1] == 8'h22, "R8 Y captured", txlog[1], 8'h22);

    // R7: trigger arriving during a response
    clear_model();
    x_in = 8'h71; y_in = 8'h72;
    send_rx(8'h31);
    idle(10);
    send_rx(8'h31);
    idle(10);
    check(nrd == 1, "R7 no read while sending", nrd, 1);
    idle(200);
    check(nrd == 2 && nlog == 4, "R7 second request served", nlog, 4);
    check(overrun == 0, "R7 no overwrite", overrun, 0);

    // R9: reset mid-response
    clear_model();
    send_rx(8'h31);
    idle(8);
    rst = 1'b1;
    idle(2);
    check(!rd_pulse && !wr_pulse, "R9 mid reset strobes", {rd_pulse, wr_pulse}, 0);
    rst = 1'b0;
    clear_model();
    idle(100);
    check(nlog == 0 && nrd == 0, "R9 idle after reset", nlog + nrd, 0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nchk++; nerr++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
    end
  end
endmodule